// File: doc/BRIEF.md
# Dual Halfword Signed Multiply-Accumulate Unit

This execution unit serves packed-halfword dot-product operations. Each of its two 32-bit source operands holds two signed 16-bit halves. The unit multiplies the low halves together and the high halves together. It then either adds the two products or subtracts the high product from the low one. It can also add a 32-bit accumulator operand to that value.

The operation and its operands are presented together with a one-cycle start strobe. One clock later the unit drives the wrapped 32-bit result and a one-cycle valid pulse. A sticky saturation flag records signed overflow in the additive forms. That flag stays set until a dedicated clear input is raised. The instruction fetch and the register file lie outside the unit. The caller supplies the 4-bit accumulator register field, and the unit decodes only the "no accumulate" value from it.

Top module: `dual_mac_unit`

## Requirements
- R1: With `diff_sel_i` = 0 (sum form), the computed value is sext(op_a[15:0])·sext(op_b[15:0]) + sext(op_a[31:16])·sext(op_b[31:16]), taken modulo 2^32.
- R2: With `diff_sel_i` = 1 (difference form), the computed value is the low-half product minus the high-half product, taken modulo 2^32.
- R3: When `acc_idx_i` is not 15, `acc_i` is added to the computed value modulo 2^32. When `acc_idx_i` equals 15, `acc_i` has no effect on the result.
- R4: In the sum form, `q_flag_o` becomes 1 when adding the two products overflows as a signed 32-bit addition. Such an overflow means both addends have the same sign and the sign of the sum differs from theirs.
- R5: In the sum form with accumulation, `q_flag_o` also becomes 1 when adding `acc_i` to the wrapped product sum overflows as a signed 32-bit addition.
- R6: The difference forms never change `q_flag_o`, with or without accumulation.
- R7: The result is never saturated. It is always the low 32 bits of the exact value, including when an overflow sets the flag.
- R8: `q_flag_o` is sticky. A later operation without overflow does not clear it. Only `q_clr_i` clears it, one clock after `q_clr_i` is sampled. If an overflow from a start and a clear arrive in the same cycle, the flag ends up set.
- R9: `result_o` and the flag update on the clock edge that samples `start_i`. `valid_o` is high for exactly the cycle after each start. While `start_i` is low, `result_o` holds its value whatever the operand inputs do.
- R10: A synchronous active-low `rst_n` clears `result_o`, `valid_o` and `q_flag_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe; operands sampled on this edge |
| op_a_i | input | 32 | First packed-halfword operand |
| op_b_i | input | 32 | Second packed-halfword operand |
| acc_i | input | 32 | Accumulator operand |
| diff_sel_i | input | 1 | 0 = add products, 1 = low minus high |
| acc_idx_i | input | 4 | Accumulator register field; 15 = no accumulation |
| q_clr_i | input | 1 | Synchronous clear of the sticky flag |
| result_o | output | 32 | Registered 32-bit result |
| valid_o | output | 1 | One-cycle pulse after a start |
| q_flag_o | output | 1 | Sticky signed-overflow flag |

## Verification
The assertions assume that the inputs are stable and known on each rising edge, and that `start_i` is meaningful only as a single-cycle pulse. Back-to-back starts are legal but are not needed by any property. The bench drives every input on the falling edge and lowers `start_i` after one cycle. It raises `q_clr_i` only in separate cycles, except for one deliberate collision of a clear with an overflowing start. The sweep draws halfwords from a small set of extreme and ordinary values in every combination, in all four forms. It pairs each combination with accumulators near the signed limits, so both overflow points and the wrap-around are reached many times.

// File: rtl/dmac_pkg.sv
`timescale 1ns/1ps
package dmac_pkg;
  typedef enum logic {
    OP_SUM  = 1'b0,
    OP_DIFF = 1'b1
  } dmac_op_e;
endpackage

// File: rtl/dmac_half_mul.sv
`timescale 1ns/1ps
module dmac_half_mul #(
  parameter int HALF_W = 16,
  localparam int PROD_W = 2 * HALF_W
) (
  input  logic [HALF_W-1:0] lhs_i,
  input  logic [HALF_W-1:0] rhs_i,
  output logic [PROD_W-1:0] prod_o
);
  logic signed [PROD_W-1:0] prod_s;

  // Full-width signed product; the single largest case (-2^(H-1))^2 still fits.
  always_comb begin
    prod_s = $signed(lhs_i) * $signed(rhs_i);
  end

  assign prod_o = prod_s;
endmodule

// File: rtl/dmac_combine.sv
`timescale 1ns/1ps
module dmac_combine
  import dmac_pkg::*;
#(
  parameter int HALF_W     = 16,
  parameter int IDX_W      = 4,
  parameter int NO_ACC_IDX = 15,
  localparam int DW        = 2 * HALF_W
) (
  input  logic [DW-1:0]    prod_lo_i,
  input  logic [DW-1:0]    prod_hi_i,
  input  logic [DW-1:0]    acc_i,
  input  dmac_op_e         op_i,
  input  logic [IDX_W-1:0] acc_idx_i,
  output logic [DW-1:0]    value_o,
  output logic             ovf_prod_o,
  output logic             ovf_acc_o
);
  // Signed overflow of a+b: equal operand signs, and the sum's sign differs.
  function automatic logic add_ovf(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [DW-1:0] s;
    s = a + b;
    return (a[DW-1] == b[DW-1]) && (s[DW-1] != a[DW-1]);
  endfunction

  logic [DW-1:0] prod_sum;
  logic [DW-1:0] prod_dif;
  logic [DW-1:0] base;
  logic          use_acc;

  always_comb begin
    prod_sum   = prod_lo_i + prod_hi_i;
    prod_dif   = prod_lo_i - prod_hi_i;
    base       = (op_i == OP_DIFF) ? prod_dif : prod_sum;
    use_acc    = (acc_idx_i != IDX_W'(NO_ACC_IDX));
    value_o    = use_acc ? (base + acc_i) : base;
    ovf_prod_o = (op_i == OP_SUM) && add_ovf(prod_lo_i, prod_hi_i);
    ovf_acc_o  = (op_i == OP_SUM) && use_acc && add_ovf(prod_sum, acc_i);
  end
endmodule

// File: rtl/dmac_sticky_flag.sv
`timescale 1ns/1ps
module dmac_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/dual_mac_unit.sv
`timescale 1ns/1ps
module dual_mac_unit
  import dmac_pkg::*;
#(
  parameter int HALF_W     = 16,
  parameter int IDX_W      = 4,
  parameter int NO_ACC_IDX = 15,
  localparam int DW        = 2 * HALF_W,
  localparam int N_HALVES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [DW-1:0]    op_a_i,
  input  logic [DW-1:0]    op_b_i,
  input  logic [DW-1:0]    acc_i,
  input  logic             diff_sel_i,
  input  logic [IDX_W-1:0] acc_idx_i,
  input  logic             q_clr_i,
  output logic [DW-1:0]    result_o,
  output logic             valid_o,
  output logic             q_flag_o
);
  logic [N_HALVES-1:0][DW-1:0] prods;
  logic [DW-1:0] value_c;
  logic          ovf_prod;
  logic          ovf_acc;
  logic          ovf_any;
  logic          q_set_evt;
  dmac_op_e      op_sel;

  for (genvar g = 0; g < N_HALVES; g++) begin : g_half
    dmac_half_mul #(.HALF_W(HALF_W)) u_mul (
      .lhs_i  (op_a_i[g*HALF_W +: HALF_W]),
      .rhs_i  (op_b_i[g*HALF_W +: HALF_W]),
      .prod_o (prods[g])
    );
  end

  assign op_sel = diff_sel_i ? OP_DIFF : OP_SUM;

  dmac_combine #(
    .HALF_W     (HALF_W),
    .IDX_W      (IDX_W),
    .NO_ACC_IDX (NO_ACC_IDX)
  ) u_comb (
    .prod_lo_i  (prods[0]),
    .prod_hi_i  (prods[1]),
    .acc_i      (acc_i),
    .op_i       (op_sel),
    .acc_idx_i  (acc_idx_i),
    .value_o    (value_c),
    .ovf_prod_o (ovf_prod),
    .ovf_acc_o  (ovf_acc)
  );

  assign ovf_any   = ovf_prod | ovf_acc;
  assign q_set_evt = start_i & ovf_any;

  dmac_sticky_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (q_set_evt),
    .clr_i  (q_clr_i),
    .flag_o (q_flag_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= start_i;
      if (start_i) result_o <= value_c;
    end
  end
endmodule

// File: rtl/dual_mac_checker.sv
`timescale 1ns/1ps
module dual_mac_checker #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          diff_sel_i,
  input logic          q_clr_i,
  input logic          ovf_any,
  input logic [DW-1:0] result_o,
  input logic          valid_o,
  input logic          q_flag_o
);
  a_r9_valid_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> valid_o);
  a_r9_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !valid_o);
  a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(result_o));
  a_r8_q_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (q_flag_o && !q_clr_i) |=> q_flag_o);
  a_r8_q_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (q_clr_i && !(start_i && ovf_any)) |=> !q_flag_o);
  a_r4_ovf_sets_q: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && ovf_any) |=> q_flag_o);
  a_r6_diff_no_q: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && diff_sel_i && !q_flag_o) |=> !q_flag_o);
endmodule

bind dual_mac_unit dual_mac_checker #(.DW(DW)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .diff_sel_i (diff_sel_i),
  .q_clr_i    (q_clr_i),
  .ovf_any    (ovf_any),
  .result_o   (result_o),
  .valid_o    (valid_o),
  .q_flag_o   (q_flag_o)
);

// File: tb/test_dual_mac_unit.sv
`timescale 1ns/1ps
module test_dual_mac_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] op_a_i = '0;
  logic [31:0] op_b_i = '0;
  logic [31:0] acc_i = '0;
  logic        diff_sel_i = 1'b0;
  logic [3:0]  acc_idx_i = 4'd15;
  logic        q_clr_i = 1'b0;
  logic [31:0] result_o;
  logic        valid_o;
  logic        q_flag_o;

  int n_checks = 0;
  int n_errors = 0;
  bit exp_q = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_mac_unit i_dual_mac_unit (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_a_i(op_a_i), .op_b_i(op_b_i),
    .acc_i(acc_i), .diff_sel_i(diff_sel_i), .acc_idx_i(acc_idx_i), .q_clr_i(q_clr_i),
    .result_o(result_o), .valid_o(valid_o), .q_flag_o(q_flag_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Reference computed with wide integer range checks rather than sign bits.
  function automatic void model(input logic [31:0] a, input logic [31:0] b,
                                input logic [31:0] acc, input bit dsel,
                                input logic [3:0] idx,
                                output logic [31:0] res, output bit ovf);
    longint plo = longint'($signed(a[15:0])) * longint'($signed(b[15:0]));
    longint phi = longint'($signed(a[31:16])) * longint'($signed(b[31:16]));
    longint t = dsel ? (plo - phi) : (plo + phi);
    longint t2;
    ovf = 1'b0;
    if (!dsel && (t > 64'sd2147483647 || t < -64'sd2147483648)) ovf = 1'b1;
    res = t[31:0];
    if (idx != 4'd15) begin
      t2 = longint'($signed(res)) + longint'($signed(acc));
      if (!dsel && (t2 > 64'sd2147483647 || t2 < -64'sd2147483648)) ovf = 1'b1;
      res = t2[31:0];
    end
  endfunction

  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic [31:0] acc,
                        input bit dsel, input logic [3:0] idx, input string req);
    logic [31:0] exp_res;
    bit ovf;
    model(a, b, acc, dsel, idx, exp_res, ovf);
    @(negedge clk);
    op_a_i = a; op_b_i = b; acc_i = acc; diff_sel_i = dsel; acc_idx_i = idx; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (ovf) exp_q = 1'b1;
    chk({req, " result"}, result_o, exp_res);
    chk({req, " q_flag"}, {31'b0, q_flag_o}, {31'b0, exp_q});
  endtask

  task automatic clear_q();
    @(negedge clk);
    q_clr_i = 1'b1;
    @(negedge clk);
    q_clr_i = 1'b0;
    exp_q = 1'b0;
    chk("R8 clear", {31'b0, q_flag_o}, 32'd0);
  endtask

  logic [15:0] hv [8];
  logic [31:0] av [8];

  initial begin
    logic [31:0] held;
    int opn;
    hv = '{16'h0000, 16'h0001, 16'hFFFF, 16'h0002, 16'h7FFF, 16'h8000, 16'hFFFE, 16'h3039};
    av = '{32'h0, 32'h1, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF, 32'h40000000,
           32'h12345678, 32'hC0000000};
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 result reset", result_o, 32'd0);
    chk("R10 valid reset", {31'b0, valid_o}, 32'd0);
    chk("R10 q reset", {31'b0, q_flag_o}, 32'd0);
    rst_n = 1'b1;

    // R1 basic sum; R9 valid pulse
    run_op(32'h0003_0002, 32'h0005_0004, 32'h0, 1'b0, 4'd15, "R1 sum");
    chk("R1 value", result_o, 32'd23);
    chk("R9 valid pulse", {31'b0, valid_o}, 32'd1);
    @(negedge clk);
    chk("R9 valid single", {31'b0, valid_o}, 32'd0);
    // R2 basic difference
    run_op(32'h0003_0002, 32'h0005_0004, 32'h0, 1'b1, 4'd15, "R2 diff");
    chk("R2 value", result_o, 32'hFFFFFFF9);
    // R3 accumulate vs field 15
    run_op(32'h0003_0002, 32'h0005_0004, 32'd100, 1'b0, 4'd3, "R3 acc");
    chk("R3 acc value", result_o, 32'd123);
    run_op(32'h0003_0002, 32'h0005_0004, 32'd100, 1'b0, 4'd15, "R3 no-acc");
    chk("R3 no-acc value", result_o, 32'd23);
    // R4/R7: both products 0x40000000, sum wraps to 0x80000000, flag set
    run_op(32'h8000_8000, 32'h8000_8000, 32'h0, 1'b0, 4'd15, "R4 prod ovf");
    chk("R7 wrap value", result_o, 32'h80000000);
    chk("R4 flag", {31'b0, q_flag_o}, 32'd1);
    // R8 sticky through a clean op
    run_op(32'h0001_0001, 32'h0001_0001, 32'h0, 1'b0, 4'd15, "R8 sticky");
    chk("R8 still set", {31'b0, q_flag_o}, 32'd1);
    clear_q();
    // R5 accumulate overflow only
    run_op(32'h0000_0001, 32'h0000_0001, 32'h7FFFFFFF, 1'b0, 4'd0, "R5 acc ovf");
    chk("R5 flag", {31'b0, q_flag_o}, 32'd1);
    clear_q();
    // R6 difference with large accumulate never sets flag
    run_op(32'h8000_7FFF, 32'h7FFF_7FFF, 32'h7FFFFFFF, 1'b1, 4'd1, "R6 diff acc");
    chk("R6 flag", {31'b0, q_flag_o}, 32'd0);
    // R8 set wins over clear in same cycle
    @(negedge clk);
    op_a_i = 32'h8000_8000; op_b_i = 32'h8000_8000; diff_sel_i = 1'b0; acc_idx_i = 4'd15;
    start_i = 1'b1; q_clr_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; q_clr_i = 1'b0; exp_q = 1'b1;
    chk("R8 set beats clear", {31'b0, q_flag_o}, 32'd1);
    clear_q();
    // R9 result held while inputs move without start
    held = result_o;
    @(negedge clk);
    op_a_i = 32'h1234_5678; op_b_i = 32'h7FFF_8000; acc_i = 32'h55; acc_idx_i = 4'd2;
    @(negedge clk);
    op_a_i = 32'h8000_8000; op_b_i = 32'h8000_8000; acc_idx_i = 4'd15;
    @(negedge clk);
    chk("R9 hold", result_o, held);
    chk("R9 no valid", {31'b0, valid_o}, 32'd0);
    chk("R9 no q from idle", {31'b0, q_flag_o}, 32'd0);

    // Sweep: R1 R2 R3 R4 R5 R6 R7
    opn = 0;
    for (int ia = 0; ia < 8; ia++)
      for (int ib = 0; ib < 8; ib++)
        for (int ic = 0; ic < 8; ic++)
          for (int id = 0; id < 8; id++)
            for (int m = 0; m < 4; m++) begin
              logic [3:0] idx;
              idx = m[1] ? 4'((opn % 15)) : 4'd15;
              run_op({hv[ia], hv[ib]}, {hv[ic], hv[id]}, av[(ia + id + m) % 8], m[0], idx,
                     m[0] ? "R2 R3 R6 sweep" : "R1 R3 R4 R5 R7 sweep");
              opn++;
              if (opn % 37 == 0) clear_q();
            end

    // R10: reset mid-run
    run_op(32'h8000_8000, 32'h8000_8000, 32'h0, 1'b0, 4'd15, "R10 pre");
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    exp_q = 1'b0;
    chk("R10 result cleared", result_o, 32'd0);
    chk("R10 q cleared", {31'b0, q_flag_o}, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule